// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block sits behind the bus interface of a parallel NOR flash and turns the stream of bus write cycles into operating-mode changes and program requests. It is synchronous. Each accepted write arrives as a one-cycle strobe with a 16-bit address and a 16-bit data word. The block follows the multi-write unlock handshake that guards every command. It keeps track of whether the part is in plain read, signature query (auto select), unlock bypass, busy or error mode. When a program command completes, it hands the program controller a start pulse together with the latched target address and data.

While a program is running, the block watches the controller's busy flag and ignores every write. When the controller finishes, the block samples the controller's error flag. If the flag is set, the block locks into error mode, and only a reset command can release it. A reset command always emits a one-cycle pulse that clears the errors. In auto select mode the block also supplies the read data for the signature and block-protection queries. The query address is split into a two-bit selector and a block index.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the mode output is read (code 0), `pgmStart` and `clrErr` are low, and `asData` is 0000h. The mode codes are: read 0, auto select 1, unlock bypass 2, busy 3, error 4.
- R2: A command starts with two unlock writes: AAh to address 555h, then 55h to address 2AAh. Addresses are compared on bits 10..0 only. Only data bits 7..0 are decoded. The third write, to any address, selects the command: 90h enters auto select, A0h arms a program, 20h enters unlock bypass.
- R3: In read or auto select mode, a write that does not continue a valid sequence puts the mode in read and produces no pulse. An unknown third-write opcode has the same effect.
- R4: Outside busy, a write of F0h to any address resets the block. So does F0h as the third write of an unlock sequence. A reset clears error mode, gives one `clrErr` pulse in the next cycle, and leaves the mode in read. The single exception is R11.
- R5: Auto select mode persists across reads. While it is active, `asData` is 0020h for selector 00 and 0097h for selector 01. In every other mode `asData` is 0000h.
- R6: In auto select mode, selector 10 returns 0001h when bit `rdBlk` of `protMask` is set and 0000h when it is clear. Selector 11 returns 0000h.
- R7: The write that follows an armed program latches its full 16-bit address and data into `pgmAddr`/`pgmData`. That write also raises `pgmStart` for exactly one cycle and switches the mode to busy, all in the cycle after the write.
- R8: In busy mode every write is ignored. Busy ends on the first cycle after the `pgmStart` cycle in which `ctlBusy` is low. The mode then returns to read, or to unlock bypass if the program was started from that mode.
- R9: If `ctlErr` is high when busy ends, the mode becomes error. In error mode every write other than a reset command is ignored.
- R10: In unlock bypass mode, A0h to any address arms a program and the next write starts it. 90h followed by 00h returns to read. 90h followed by any other byte stays in bypass. All other writes are ignored.
- R11: A reset, or a program that completes, while unlock bypass mode is in effect leaves the mode in unlock bypass. This includes an error raised by a program started from bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStb | input | 1 | One-cycle strobe for an accepted bus write |
| wrAddr | input | 16 | Bus write address |
| wrData | input | 16 | Bus write data; bits 7..0 are decoded |
| rdBlk | input | 4 | Block index of the query read (address bits 15..12) |
| rdSel | input | 2 | Query selector (address bits 1..0) |
| protMask | input | 16 | Per-block protection flags, one bit per block |
| ctlBusy | input | 1 | Program controller busy |
| ctlErr | input | 1 | Program controller error |
| mode | output | 3 | Current mode code |
| pgmStart | output | 1 | One-cycle program start pulse |
| pgmAddr | output | 16 | Latched program address |
| pgmData | output | 16 | Latched program data |
| clrErr | output | 1 | One-cycle reset-errors pulse |
| asData | output | 16 | Auto select read data |

## Verification
A hidden sequence step that is wrong shows up at the ports only on the next write. That write then lands in the wrong mode or pulses `pgmStart` when it should not. The bench therefore checks the mode after every write and compares every pulse against a queue of expected events. A wrong busy or error flag shows up one cycle after the controller flags change, either as a stuck busy mode or as a reset that fails to release error mode. The return-to-bypass rule can only be seen after a full busy round trip, so each such case runs the program to completion before it checks the mode.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    MODE_READ = 3'd0,
    MODE_ASEL = 3'd1,
    MODE_BYP  = 3'd2,
    MODE_BUSY = 3'd3,
    MODE_ERR  = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_U1,
    SQ_U2,
    SQ_PGM,
    SQ_BPGM,
    SQ_BEXIT
  } seq_e;

  typedef enum logic [1:0] {
    BASE_READ,
    BASE_ASEL,
    BASE_BYP
  } base_e;

  typedef struct packed {
    logic latchPgm;
    logic clrErr;
  } strobe_t;

  localparam logic [7:0] OP_UNLK1 = 8'hAA;
  localparam logic [7:0] OP_UNLK2 = 8'h55;
  localparam logic [7:0] OP_RESET = 8'hF0;
  localparam logic [7:0] OP_ASEL  = 8'h90;
  localparam logic [7:0] OP_PGM   = 8'hA0;
  localparam logic [7:0] OP_BYP   = 8'h20;
  localparam logic [7:0] OP_BEXIT = 8'h00;
endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int CMP_W = 11,
  parameter logic [CMP_W-1:0] UNLK1_ADDR = 'h555,
  parameter logic [CMP_W-1:0] UNLK2_ADDR = 'h2AA
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStb,
  input  logic [CMP_W-1:0] cmpAddr,
  input  logic [7:0]       cmdByte,
  input  logic             ctlBusy,
  input  logic             ctlErr,
  output mode_e            modeOut,
  output strobe_t          strb
);
  seq_e  seqQ, seqN;
  base_e baseQ, baseN;
  logic  busyQ, busyN;
  logic  firstQ, firstN;
  logic  errQ, errN;
  logic  bypRetQ, bypRetN;

  logic isReset, isUnlk1, isUnlk2;
  assign isReset = (cmdByte == OP_RESET);
  assign isUnlk1 = (cmpAddr == UNLK1_ADDR) && (cmdByte == OP_UNLK1);
  assign isUnlk2 = (cmpAddr == UNLK2_ADDR) && (cmdByte == OP_UNLK2);

  always_comb begin
    seqN    = seqQ;
    baseN   = baseQ;
    busyN   = busyQ;
    firstN  = 1'b0;
    errN    = errQ;
    bypRetN = bypRetQ;
    strb    = '0;
    if (busyQ) begin
      if (!firstQ && !ctlBusy) begin
        busyN = 1'b0;
        errN  = ctlErr;
        baseN = bypRetQ ? BASE_BYP : BASE_READ;
      end
    end else if (wrStb) begin
      unique case (seqQ)
        SQ_PGM, SQ_BPGM: begin
          strb.latchPgm = 1'b1;
          busyN   = 1'b1;
          firstN  = 1'b1;
          bypRetN = (seqQ == SQ_BPGM);
          seqN    = SQ_IDLE;
        end
        SQ_BEXIT: begin
          seqN = SQ_IDLE;
          if (cmdByte == OP_BEXIT) baseN = BASE_READ;
        end
        SQ_U1: begin
          if (isReset) begin
            seqN = SQ_IDLE;
            errN = 1'b0;
            strb.clrErr = 1'b1;
            baseN = (baseQ == BASE_BYP) ? BASE_BYP : BASE_READ;
          end else if (isUnlk2) begin
            seqN = SQ_U2;
          end else begin
            seqN = SQ_IDLE;
            if (!errQ && baseQ != BASE_BYP) baseN = BASE_READ;
          end
        end
        SQ_U2: begin
          seqN = SQ_IDLE;
          if (isReset) begin
            errN = 1'b0;
            strb.clrErr = 1'b1;
            baseN = (baseQ == BASE_BYP) ? BASE_BYP : BASE_READ;
          end else if (!errQ) begin
            unique case (cmdByte)
              OP_ASEL: baseN = BASE_ASEL;
              OP_PGM:  seqN  = SQ_PGM;
              OP_BYP:  baseN = BASE_BYP;
              default: baseN = BASE_READ;
            endcase
          end
        end
        default: begin
          if (isReset) begin
            errN = 1'b0;
            strb.clrErr = 1'b1;
            baseN = (baseQ == BASE_BYP) ? BASE_BYP : BASE_READ;
          end else if (errQ) begin
            if (isUnlk1) seqN = SQ_U1;
          end else if (baseQ == BASE_BYP) begin
            if (cmdByte == OP_PGM)       seqN = SQ_BPGM;
            else if (cmdByte == OP_ASEL) seqN = SQ_BEXIT;
          end else if (isUnlk1) begin
            seqN = SQ_U1;
          end else begin
            baseN = BASE_READ;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ    <= SQ_IDLE;
      baseQ   <= BASE_READ;
      busyQ   <= 1'b0;
      firstQ  <= 1'b0;
      errQ    <= 1'b0;
      bypRetQ <= 1'b0;
    end else begin
      seqQ    <= seqN;
      baseQ   <= baseN;
      busyQ   <= busyN;
      firstQ  <= firstN;
      errQ    <= errN;
      bypRetQ <= bypRetN;
    end
  end

  always_comb begin
    if (busyQ)      modeOut = MODE_BUSY;
    else if (errQ)  modeOut = MODE_ERR;
    else begin
      unique case (baseQ)
        BASE_ASEL: modeOut = MODE_ASEL;
        BASE_BYP:  modeOut = MODE_BYP;
        default:   modeOut = MODE_READ;
      endcase
    end
  end
endmodule

// File: rtl/fcs_dpath.sv
module fcs_dpath
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BLK_BITS = 4,
  parameter logic [DATA_W-1:0] MFR_CODE = 'h0020,
  parameter logic [DATA_W-1:0] DEV_CODE = 'h0097
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  mode_e                  modeIn,
  input  logic [BLK_BITS-1:0]    rdBlk,
  input  logic [1:0]             rdSel,
  input  logic [2**BLK_BITS-1:0] protMask,
  output logic                   pgmStart,
  output logic [ADDR_W-1:0]      pgmAddr,
  output logic [DATA_W-1:0]      pgmData,
  output logic                   clrErr,
  output logic [DATA_W-1:0]      asData
);
  localparam int NBLK = 2**BLK_BITS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgmStart <= 1'b0;
      clrErr   <= 1'b0;
      pgmAddr  <= '0;
      pgmData  <= '0;
    end else begin
      pgmStart <= strb.latchPgm;
      clrErr   <= strb.clrErr;
      if (strb.latchPgm) begin
        pgmAddr <= wrAddr;
        pgmData <= wrData;
      end
    end
  end

  logic [NBLK-1:0] blkHit;
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign blkHit[b] = protMask[b] && (rdBlk == BLK_BITS'(b));
  end

  always_comb begin
    asData = '0;
    if (modeIn == MODE_ASEL) begin
      unique case (rdSel)
        2'b00:   asData = MFR_CODE;
        2'b01:   asData = DEV_CODE;
        2'b10:   asData = {{(DATA_W-1){1'b0}}, |blkHit};
        default: asData = '0;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BLK_BITS = 4,
  parameter int CMP_W = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrStb,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [BLK_BITS-1:0]    rdBlk,
  input  logic [1:0]             rdSel,
  input  logic [2**BLK_BITS-1:0] protMask,
  input  logic                   ctlBusy,
  input  logic                   ctlErr,
  output logic [2:0]             mode,
  output logic                   pgmStart,
  output logic [ADDR_W-1:0]      pgmAddr,
  output logic [DATA_W-1:0]      pgmData,
  output logic                   clrErr,
  output logic [DATA_W-1:0]      asData
);
  mode_e   curMode;
  strobe_t strb;

  fcs_ctrl #(.CMP_W(CMP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb),
    .cmpAddr(wrAddr[CMP_W-1:0]), .cmdByte(wrData[7:0]),
    .ctlBusy(ctlBusy), .ctlErr(ctlErr),
    .modeOut(curMode), .strb(strb)
  );

  fcs_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_BITS(BLK_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .wrData(wrData), .modeIn(curMode),
    .rdBlk(rdBlk), .rdSel(rdSel), .protMask(protMask),
    .pgmStart(pgmStart), .pgmAddr(pgmAddr), .pgmData(pgmData),
    .clrErr(clrErr), .asData(asData)
  );

  assign mode = curMode;
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStb,
  input logic              ctlBusy,
  input logic [2:0]        mode,
  input logic              pgmStart,
  input logic [ADDR_W-1:0] pgmAddr,
  input logic              clrErr,
  input logic [DATA_W-1:0] asData
);
  assert_legal_mode_R1: assert property (@(posedge clk) disable iff (!rstN)
    mode <= 3'd4);

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    pgmStart |-> mode == 3'd3);

  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    pgmStart |=> !pgmStart);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd3 && !pgmStart && ctlBusy) |=> mode == 3'd3);

  assert_busy_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd3) |=> $stable(pgmAddr));

  assert_clr_mode_R4: assert property (@(posedge clk) disable iff (!rstN)
    clrErr |-> (mode == 3'd0 || mode == 3'd2));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd4 && !wrStb) |=> mode == 3'd4);

  assert_err_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd4) |=> (mode == 3'd4 || clrErr));

  assert_asdata_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 3'd1) |-> asData == '0);
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .ctlBusy(ctlBusy), .mode(mode),
  .pgmStart(pgmStart), .pgmAddr(pgmAddr), .clrErr(clrErr), .asData(asData)
);

// File: tb/sim_nor_cmd_decoder.sv
module sim_nor_cmd_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  rdBlk = '0;
  logic [1:0]  rdSel = '0;
  logic [15:0] protMask = 16'h0005;
  logic        ctlBusy = 1'b0;
  logic        ctlErr = 1'b0;
  logic [2:0]  mode;
  logic        pgmStart, clrErr;
  logic [15:0] pgmAddr, pgmData, asData;

  always #5 clk = ~clk;

  nor_cmd_decoder u0 (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .rdBlk(rdBlk), .rdSel(rdSel), .protMask(protMask),
    .ctlBusy(ctlBusy), .ctlErr(ctlErr), .mode(mode),
    .pgmStart(pgmStart), .pgmAddr(pgmAddr), .pgmData(pgmData),
    .clrErr(clrErr), .asData(asData)
  );

  typedef struct {
    bit          isPgm;
    logic [15:0] a;
    logic [15:0] d;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   nChk = 0;
  int   nFail = 0;
  bit   done = 1'b0;

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkMode(input string tag, input logic [2:0] exp);
    check16(tag, {13'b0, mode}, {13'b0, exp});
  endtask

  task automatic expectPgm(input logic [15:0] a, input logic [15:0] d, input string tag);
    exp_t e;
    e.isPgm = 1'b1; e.a = a; e.d = d; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic expectClr(input string tag);
    exp_t e;
    e.isPgm = 1'b0; e.a = '0; e.d = '0; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wrStb = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic endBusy(input logic err);
    @(negedge clk);
    ctlBusy = 1'b0; ctlErr = err;
    @(negedge clk);
  endtask

  // Monitor: every pulse must match the next queued expectation.
  always @(negedge clk) begin
    if (rstN && (pgmStart || clrErr)) begin
      if (expQ.size() == 0) begin
        nChk++; nFail++;
        $display("FAIL R4/R7 unexpected pulse: actual start=%0b clr=%0b expected none",
                 pgmStart, clrErr);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check16({e.tag, " pulse kind"}, {15'b0, pgmStart}, {15'b0, e.isPgm});
        check16({e.tag, " clr pulse"}, {15'b0, clrErr}, {15'b0, !e.isPgm});
        if (e.isPgm) begin
          check16({e.tag, " addr"}, pgmAddr, e.a);
          check16({e.tag, " data"}, pgmData, e.d);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    checkMode("R1 mode", 3'd0);
    check16("R1 pgmStart", {15'b0, pgmStart}, 16'h0);
    check16("R1 clrErr", {15'b0, clrErr}, 16'h0);
    check16("R1 asData", asData, 16'h0);

    // R5 / R6 auto select queries
    unlock();
    wr(16'h0555, 16'h0090);
    checkMode("R5 enter asel", 3'd1);
    rdSel = 2'b00; rdBlk = 4'h3; tick(1);
    check16("R5 mfr code", asData, 16'h0020);
    rdSel = 2'b01; rdBlk = 4'hA; tick(1);
    check16("R5 dev code", asData, 16'h0097);
    rdSel = 2'b10; rdBlk = 4'h0; tick(1);
    check16("R6 blk0 protected", asData, 16'h0001);
    rdBlk = 4'h1; tick(1);
    check16("R6 blk1 open", asData, 16'h0000);
    rdBlk = 4'h2; tick(1);
    check16("R6 blk2 protected", asData, 16'h0001);
    rdSel = 2'b11; tick(1);
    check16("R6 sel11 zero", asData, 16'h0000);
    checkMode("R5 asel persists", 3'd1);

    // R4 single reset from auto select
    expectClr("R4 single reset");
    wr(16'h7777, 16'h00F0);
    checkMode("R4 back to read", 3'd0);
    rdSel = 2'b00; tick(1);
    check16("R5 asData idle in read", asData, 16'h0000);
    tick(2);

    // R2 upper data bits and upper address bits ignored
    wr(16'hF555, 16'hFFAA);
    wr(16'h32AA, 16'h1255);
    wr(16'h1234, 16'h5590);
    checkMode("R2 masked decode asel", 3'd1);

    // R3 broken sequence from auto select
    wr(16'h0555, 16'h00AA);
    wr(16'h02AB, 16'h0055);
    checkMode("R3 break to read", 3'd0);
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0012);
    checkMode("R3 bad second write", 3'd0);
    unlock();
    wr(16'h0555, 16'h0077);
    checkMode("R3 unknown opcode", 3'd0);

    // R4 three-write reset
    unlock();
    wr(16'h0555, 16'h0090);
    checkMode("R4 asel again", 3'd1);
    expectClr("R4 three-write reset");
    unlock();
    wr(16'h0555, 16'h00F0);
    checkMode("R4 three-write read", 3'd0);
    tick(2);

    // R7 program then R8 busy ignore
    unlock();
    wr(16'h0555, 16'h00A0);
    expectPgm(16'hBEEF, 16'h1234, "R7 program");
    wr(16'hBEEF, 16'h1234);
    checkMode("R7 busy after start", 3'd3);
    ctlBusy = 1'b1;
    wr(16'h0000, 16'h00F0);
    unlock();
    wr(16'h0555, 16'h00A0);
    wr(16'h1111, 16'h2222);
    checkMode("R8 writes ignored", 3'd3);
    check16("R8 addr held", pgmAddr, 16'hBEEF);
    endBusy(1'b0);
    checkMode("R8 busy ends to read", 3'd0);

    // R9 error lockout
    unlock();
    wr(16'h0555, 16'h00A0);
    expectPgm(16'h0042, 16'h00F0, "R9 program");
    wr(16'h0042, 16'h00F0);
    ctlBusy = 1'b1;
    tick(2);
    endBusy(1'b1);
    checkMode("R9 error mode", 3'd4);
    unlock();
    wr(16'h0555, 16'h0090);
    checkMode("R9 asel ignored", 3'd4);
    wr(16'h0555, 16'h00A0);
    checkMode("R9 A0 ignored", 3'd4);
    expectClr("R9 reset clears");
    wr(16'h0100, 16'h00F0);
    ctlErr = 1'b0;
    checkMode("R9 cleared to read", 3'd0);
    tick(2);

    // R10 unlock bypass
    unlock();
    wr(16'h0555, 16'h0020);
    checkMode("R10 enter bypass", 3'd2);
    rdSel = 2'b00; tick(1);
    check16("R5 asData in bypass", asData, 16'h0000);
    wr(16'h0555, 16'h0012);
    wr(16'h0555, 16'h00AA);
    checkMode("R10 others ignored", 3'd2);
    wr(16'h0000, 16'h00A0);
    expectPgm(16'h4000, 16'hABCD, "R10 bypass program");
    wr(16'h4000, 16'hABCD);
    checkMode("R8 busy in bypass", 3'd3);
    tick(1);
    checkMode("R8 minimum busy cycle", 3'd3);
    tick(1);
    checkMode("R11 return to bypass", 3'd2);

    // R11 reset inside bypass
    expectClr("R11 reset in bypass");
    wr(16'h0300, 16'h00F0);
    checkMode("R11 reset keeps bypass", 3'd2);
    tick(2);

    // R11 error from bypass program
    wr(16'h0000, 16'h00A0);
    expectPgm(16'h8001, 16'h0000, "R11 bypass program err");
    wr(16'h8001, 16'h0000);
    ctlBusy = 1'b1;
    tick(1);
    endBusy(1'b1);
    checkMode("R11 error from bypass", 3'd4);
    expectClr("R11 error reset");
    wr(16'h0000, 16'h00F0);
    ctlErr = 1'b0;
    checkMode("R11 back to bypass", 3'd2);
    tick(2);

    // R10 exit pairs
    wr(16'h0000, 16'h0090);
    wr(16'h0000, 16'h0055);
    checkMode("R10 bad exit stays", 3'd2);
    wr(16'h0000, 16'h0090);
    wr(16'h0000, 16'h0000);
    checkMode("R10 exit to read", 3'd0);

    tick(3);
    nChk++;
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL R4/R7 pending pulses: actual %0d expected 0", expQ.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule